// File: doc/BRIEF.md
# Critical-Cell Crossbar Matching Scheduler

This block sets up the crossbar of an N-port switch that has twice the line rate inside the fabric. Each time slot runs four steps in a fixed order: cells arrive, a first transfer is scheduled, cells depart at the outputs, and a second transfer is scheduled. The scheduler is started once for each of the two transfer steps. Queue storage, arrival handling, and the choice of which cell leaves each output are handled outside. The rule at each output is that the cell with the earliest leave time goes first.

On a start pulse the scheduler takes a snapshot of one candidate cell for each (input, output) pair. Each candidate carries a valid bit, a signed slack value, and two ranks. Slack is the output cushion minus the input thread. The input rank is the cell's place in its input's priority list, and the output rank is its place in its output's priority list. Only zero-slack cells take part. The scheduler then grants one cell per clock. The cell it grants is a "sink": a live cell with no live cell ahead of it in its input list or in its output list. After each grant it removes every cell that shares that input or that output. The grants build up into a conflict-free matching. That matching drives the crossbar until the next start.

Top module: `crit_match_sched`

## Requirements
- R1: The clock edge that samples `start` high clears all grants and raises `busy`, so in the next cycle `gnt_vld` is all zero and `busy` is 1.
- R2: A cell takes part only if `cell_vld` is set for it and its signed `cell_slack` is exactly zero. A cell with positive or negative slack, or an invalid cell, is never granted.
- R3: Every input is granted at most one output, and every output is granted to at most one input. Bit `i*N+j` of `gnt_oh` means input i drives output j.
- R4: A zero-slack cell that is ahead of every other live cell in both its input list and its output list is granted.
- R5: The scheduler adds at most one grant per clock. The first grant appears one edge after the start edge.
- R6: When several sinks exist in the same clock, the sink on the lowest-numbered input is granted first.
- R7: `done` is a one-cycle pulse, and `busy` falls in the same cycle. Let k be the number of grants made. If k < N, `done` rises k+1 edges after the start edge. If k = N, it rises N edges after the start edge.
- R8: Between a `done` pulse and the next `start`, `gnt_oh`, `gnt_vld` and `gnt_phase` do not change, whatever the cell inputs do.
- R9: A grant removes every cell that shares its input or its output. A cell that was blocked only by removed cells can then be granted in a later clock.
- R10: `gnt_phase` shows the `phase_sel` value that was sampled with `start` (0 = first transfer step, 1 = second).
- R11: A smaller rank value means nearer the head of a list. When the run ends because all live cells are gone, the matching is stable. Stable means every zero-slack cell was granted, or its input was granted to a cell with a smaller input rank, or its output was granted to a cell with a smaller output rank. If live cells remain but none is a sink (the rank lists form a cycle), the run ends with no further grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins one matching and samples all cell inputs |
| phase_sel | input | 1 | Transfer step tag sampled with start |
| cell_vld | input | N*N | A candidate is present for pair (i,j), bit i*N+j |
| cell_slack | input | N*N*SW | Signed slack for each pair |
| in_rank | input | N*N*RW | Position of each pair's cell in its input list |
| out_rank | input | N*N*RW | Position of each pair's cell in its output list |
| gnt_oh | output | N*N | One-hot output select for each input |
| gnt_vld | output | N | Input i holds a grant |
| gnt_phase | output | 1 | Tag of the step that the grants belong to |
| done | output | 1 | Matching finished, one-cycle pulse |
| busy | output | 1 | Matching in progress |

## Verification
Suppose the live-cell mask goes wrong, for example a row or column is not removed. That shows at the ports in the same cycle as the grant: a second bit in one input's or one output's grant lines, or a cell granted while a cell ahead of it in a shared list was never served. Suppose the iteration count or the sink search goes wrong. Then `done` arrives at a cycle other than k+1 edges after the start edge (or N edges when every input is matched), and the per-cycle trace of `gnt_vld` shows the wrong grant order among simultaneous sinks. A snapshot that is not held shows as grants or a phase tag that change while the scheduler is idle.

// File: rtl/xs_pkg.sv
package xs_pkg;
  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_RUN  = 1'b1
  } xs_run_e;
endpackage

// File: rtl/xs_rst_sync.sv
module xs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/xs_sink_find.sv
module xs_sink_find #(
  parameter int N  = 4,
  parameter int RW = 4
) (
  input  logic [N*N-1:0]         live,
  input  logic [N*N-1:0][RW-1:0] in_r,
  input  logic [N*N-1:0][RW-1:0] out_r,
  output logic [N*N-1:0]         sink
);
  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      logic blk;

      // a cell is blocked by any live cell ahead of it in either list
      always_comb begin
        blk = 1'b0;
        for (int k = 0; k < N; k++) begin
          if (k != gj && live[gi*N+k] && (in_r[gi*N+k] < in_r[gi*N+gj])) begin
            blk = 1'b1;
          end
          if (k != gi && live[k*N+gj] && (out_r[k*N+gj] < out_r[gi*N+gj])) begin
            blk = 1'b1;
          end
        end
      end

      assign sink[gi*N+gj] = live[gi*N+gj] & ~blk;
    end
  end
endmodule

// File: rtl/xs_pick.sv
module xs_pick #(
  parameter int N = 4
) (
  input  logic [N*N-1:0] sink,
  output logic           pick_vld,
  output logic [N*N-1:0] pick_cell,
  output logic [N-1:0]   pick_in,
  output logic [N-1:0]   pick_out
);
  // scan inputs from 0 upward, then outputs within the input
  always_comb begin
    pick_vld  = 1'b0;
    pick_cell = '0;
    pick_in   = '0;
    pick_out  = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (!pick_vld && sink[i*N+j]) begin
          pick_vld       = 1'b1;
          pick_cell[i*N+j] = 1'b1;
          pick_in[i]     = 1'b1;
          pick_out[j]    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xs_ctrl.sv
module xs_ctrl
  import xs_pkg::*;
#(
  parameter int N  = 4,
  parameter int RW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   phase_sel,
  input  logic [N*N-1:0]         act_in,
  input  logic [N*N-1:0][RW-1:0] in_r_in,
  input  logic [N*N-1:0][RW-1:0] out_r_in,
  input  logic                   pick_vld,
  input  logic [N*N-1:0]         pick_cell,
  input  logic [N-1:0]           pick_in,
  input  logic [N-1:0]           pick_out,
  output logic [N*N-1:0]         live_q,
  output logic [N*N-1:0][RW-1:0] in_r_q,
  output logic [N*N-1:0][RW-1:0] out_r_q,
  output logic [N*N-1:0]         gnt_q,
  output logic                   phase_q,
  output logic                   busy_q,
  output logic                   done_q
);
  localparam int IW = $clog2(N + 1);
  localparam logic [IW-1:0] LAST_ITER = IW'(N - 1);

  xs_run_e           st_q, st_n;
  logic [IW-1:0]     iter_q, iter_n;
  logic [N*N-1:0]    live_n, gnt_n, kill;
  logic              phase_n, done_n;
  logic              cap_en;

  for (genvar gc = 0; gc < N*N; gc++) begin : g_kill
    assign kill[gc] = pick_in[gc / N] | pick_out[gc % N];
  end

  assign cap_en = start;

  always_comb begin
    st_n    = st_q;
    iter_n  = iter_q;
    live_n  = live_q;
    gnt_n   = gnt_q;
    phase_n = phase_q;
    done_n  = 1'b0;
    if (start) begin
      st_n    = XS_RUN;
      iter_n  = '0;
      live_n  = act_in;
      gnt_n   = '0;
      phase_n = phase_sel;
    end else if (st_q == XS_RUN) begin
      if (pick_vld) begin
        gnt_n  = gnt_q | pick_cell;
        live_n = live_q & ~kill;
        iter_n = iter_q + 1'b1;
        if (iter_q == LAST_ITER) begin
          st_n   = XS_IDLE;
          done_n = 1'b1;
        end
      end else begin
        st_n   = XS_IDLE;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XS_IDLE;
      iter_q  <= '0;
      live_q  <= '0;
      gnt_q   <= '0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      iter_q  <= iter_n;
      live_q  <= live_n;
      gnt_q   <= gnt_n;
      phase_q <= phase_n;
      done_q  <= done_n;
    end
  end

  // rank snapshot, loaded only on start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_r_q  <= '0;
      out_r_q <= '0;
    end else if (cap_en) begin
      in_r_q  <= in_r_in;
      out_r_q <= out_r_in;
    end
  end

  assign busy_q = (st_q == XS_RUN);
endmodule

// File: rtl/crit_match_sched.sv
module crit_match_sched #(
  parameter int N  = 4,
  parameter int RW = 4,
  parameter int SW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              phase_sel,
  input  logic [N*N-1:0]    cell_vld,
  input  logic [N*N*SW-1:0] cell_slack,
  input  logic [N*N*RW-1:0] in_rank,
  input  logic [N*N*RW-1:0] out_rank,
  output logic [N*N-1:0]    gnt_oh,
  output logic [N-1:0]      gnt_vld,
  output logic              gnt_phase,
  output logic              done,
  output logic              busy
);
  logic                   rst_q_n;
  logic [N*N-1:0]         act_in, live_q, sink, pick_cell, gnt_q;
  logic [N*N-1:0][RW-1:0] in_r_in, out_r_in, in_r_q, out_r_q;
  logic                   pick_vld;
  logic [N-1:0]           pick_in, pick_out;

  xs_rst_sync i_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  for (genvar gc = 0; gc < N*N; gc++) begin : g_cell
    assign act_in[gc]   = cell_vld[gc] && (cell_slack[gc*SW +: SW] == '0);
    assign in_r_in[gc]  = in_rank[gc*RW +: RW];
    assign out_r_in[gc] = out_rank[gc*RW +: RW];
  end

  xs_sink_find #(.N(N), .RW(RW)) i_sink (
    .live  (live_q),
    .in_r  (in_r_q),
    .out_r (out_r_q),
    .sink  (sink)
  );

  xs_pick #(.N(N)) i_pick (
    .sink      (sink),
    .pick_vld  (pick_vld),
    .pick_cell (pick_cell),
    .pick_in   (pick_in),
    .pick_out  (pick_out)
  );

  xs_ctrl #(.N(N), .RW(RW)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start     (start),
    .phase_sel (phase_sel),
    .act_in    (act_in),
    .in_r_in   (in_r_in),
    .out_r_in  (out_r_in),
    .pick_vld  (pick_vld),
    .pick_cell (pick_cell),
    .pick_in   (pick_in),
    .pick_out  (pick_out),
    .live_q    (live_q),
    .in_r_q    (in_r_q),
    .out_r_q   (out_r_q),
    .gnt_q     (gnt_q),
    .phase_q   (gnt_phase),
    .busy_q    (busy),
    .done_q    (done)
  );

  for (genvar gi = 0; gi < N; gi++) begin : g_in
    assign gnt_vld[gi] = |gnt_q[gi*N +: N];
  end

  assign gnt_oh = gnt_q;
endmodule

// File: rtl/xs_chk.sv
module xs_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [N*N-1:0] gnt_oh,
  input logic [N-1:0]   gnt_vld
);
  localparam int CW = $clog2(N + 1) + 1;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (start) begin
      run_cnt <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    logic [N-1:0] row;
    assign row = gnt_oh[gi*N +: N];
    a_r3_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row));
  end

  for (genvar gj = 0; gj < N; gj++) begin : g_colc
    logic [N-1:0] col;
    for (genvar gk = 0; gk < N; gk++) begin : g_bit
      assign col[gk] = gnt_oh[gk*N+gj];
    end
    a_r3_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (gnt_vld == '0) && busy);

  a_r5_one_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(gnt_vld) <= $countones($past(gnt_vld)) + 1));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(gnt_oh) && $stable(gnt_vld));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < CW'(N)));
endmodule

bind crit_match_sched xs_chk #(.N(N)) i_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .gnt_oh  (gnt_oh),
  .gnt_vld (gnt_vld)
);

// File: tb/test_crit_match_sched.sv
`timescale 1ns/1ps
module test_crit_match_sched;
  localparam int N  = 4;
  localparam int RW = 4;
  localparam int SW = 6;
  localparam int NV = 9;

  // {vld, zero-slack mask, in_dir, out_dir, expected grants, expected done cycle}
  localparam logic [53:0] TBL [NV] = '{
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 16'h8421, 4'd4},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 16'h1248, 4'd4},
    {16'hFFFF, 16'h0220, 1'b0, 1'b0, 16'h0020, 4'd2},
    {16'h2084, 16'hFFFF, 1'b0, 1'b0, 16'h2084, 4'd4},
    {16'h0000, 16'hFFFF, 1'b0, 1'b0, 16'h0000, 4'd1},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'h8421, 4'd4},
    {16'hFFFF, 16'h0013, 1'b0, 1'b0, 16'h0001, 4'd2},
    {16'hFFFF, 16'h0013, 1'b1, 1'b0, 16'h0012, 4'd3},
    {16'h00F0, 16'hFFFF, 1'b1, 1'b0, 16'h0080, 4'd2}
  };

  logic              clk, rst_n, start, phase_sel;
  logic [N*N-1:0]    cell_vld;
  logic [N*N*SW-1:0] cell_slack;
  logic [N*N*RW-1:0] in_rank, out_rank;
  logic [N*N-1:0]    gnt_oh;
  logic [N-1:0]      gnt_vld;
  logic              gnt_phase, done, busy;
  logic [N*N-1:0]    zmask;
  logic [N-1:0]      trace [16];
  int n_chk, n_bad;

  crit_match_sched #(.N(N), .RW(RW), .SW(SW)) i_crit_match_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_sel(phase_sel),
    .cell_vld(cell_vld), .cell_slack(cell_slack), .in_rank(in_rank),
    .out_rank(out_rank), .gnt_oh(gnt_oh), .gnt_vld(gnt_vld),
    .gnt_phase(gnt_phase), .done(done), .busy(busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic set_ranks(input bit ind, input bit outd);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        in_rank[(i*N+j)*RW +: RW]  = RW'(ind  ? N-1-j : j);
        out_rank[(i*N+j)*RW +: RW] = RW'(outd ? N-1-i : i);
      end
    end
  endtask

  // zero slack where zm is set, otherwise alternate positive and negative
  task automatic set_slack(input logic [N*N-1:0] zm);
    zmask = zm;
    for (int c = 0; c < N*N; c++) begin
      cell_slack[c*SW +: SW] = zm[c] ? '0 : ((c % 2 == 1) ? SW'(5) : SW'(-3));
    end
  endtask

  task automatic run_phase(input bit ph, output int cyc);
    @(negedge clk);
    phase_sel = ph;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(gnt_vld == '0 && busy == 1'b1 && done == 1'b0, "R1 start clears",
        {gnt_vld, busy}, 32'h1);
    cyc = 0;
    for (int t = 0; t < 16; t++) trace[t] = '0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc < 16) trace[cyc] = gnt_vld;
      if (done) break;
      if (cyc > 20) begin
        chk(1'b0, "R7 run watchdog", cyc, N);
        break;
      end
    end
  endtask

  function automatic bit stable_ok();
    logic [N*N-1:0] act;
    act = cell_vld & zmask;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (act[i*N+j] && !gnt_oh[i*N+j]) begin
          bit served = 1'b0;
          for (int k = 0; k < N; k++) begin
            if (gnt_oh[i*N+k] && act[i*N+k] &&
                in_rank[(i*N+k)*RW +: RW] < in_rank[(i*N+j)*RW +: RW]) served = 1'b1;
            if (gnt_oh[k*N+j] && act[k*N+j] &&
                out_rank[(k*N+j)*RW +: RW] < out_rank[(i*N+j)*RW +: RW]) served = 1'b1;
          end
          if (!served) return 1'b0;
        end
      end
    end
    return 1'b1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int cyc;
    logic [N*N-1:0] eg, hold_g;
    logic [N-1:0] ev;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    start = 1'b0;
    phase_sel = 1'b0;
    cell_vld = '0;
    set_ranks(1'b0, 1'b0);
    set_slack('1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(gnt_oh == '0 && gnt_vld == '0 && !busy && !done, "R1 reset state",
        {gnt_oh, busy, done}, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      cell_vld = TBL[v][53:38];
      set_slack(TBL[v][37:22]);
      set_ranks(TBL[v][21], TBL[v][20]);
      eg = TBL[v][19:4];
      for (int i = 0; i < N; i++) ev[i] = |eg[i*N +: N];
      run_phase(v[0], cyc);
      chk(gnt_oh == eg, "R2 R4 R9 grant pattern", gnt_oh, eg);
      chk(gnt_vld == ev, "R3 grant valid bits", gnt_vld, ev);
      chk(cyc == int'(TBL[v][3:0]), "R7 done timing", cyc, TBL[v][3:0]);
      chk(!busy, "R7 busy falls with done", busy, 0);
      chk(gnt_phase == v[0], "R10 phase tag", gnt_phase, v[0]);
      chk(stable_ok(), "R11 stable matching", gnt_oh, eg);
    end

    // R5 R6: three independent sinks granted one per clock, lowest input first
    cell_vld = 16'h2084;
    set_slack('1);
    set_ranks(1'b0, 1'b0);
    run_phase(1'b0, cyc);
    chk(trace[1] == 4'b0001, "R6 lowest input first", trace[1], 4'b0001);
    chk(trace[2] == 4'b0011, "R5 second grant", trace[2], 4'b0011);
    chk(trace[3] == 4'b1011, "R5 third grant", trace[3], 4'b1011);

    // R11: rank cycle with no sink ends at once with no grant
    cell_vld = 16'h0033;
    set_slack('1);
    set_ranks(1'b0, 1'b0);
    in_rank[(1*N+1)*RW +: RW]  = RW'(0);
    in_rank[(1*N+0)*RW +: RW]  = RW'(1);
    out_rank[(1*N+0)*RW +: RW] = RW'(0);
    out_rank[(0*N+0)*RW +: RW] = RW'(1);
    run_phase(1'b1, cyc);
    chk(gnt_oh == '0, "R11 cycle gives no grant", gnt_oh, 0);
    chk(cyc == 1, "R11 cycle ends run", cyc, 1);

    // R9 then R8: removal unblocks, then grants hold while inputs move
    cell_vld = '1;
    set_slack(16'h0013);
    set_ranks(1'b1, 1'b0);
    run_phase(1'b1, cyc);
    chk(gnt_oh == 16'h0012, "R9 unblocked after removal", gnt_oh, 16'h0012);
    hold_g = gnt_oh;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      cell_vld = 16'(t * 16'h1357);
      set_slack(16'(t * 16'h0F0F));
      set_ranks(t[0], t[1]);
      phase_sel = t[0];
    end
    @(negedge clk);
    chk(gnt_oh == hold_g, "R8 grants held", gnt_oh, hold_g);
    chk(gnt_phase == 1'b1, "R8 phase held", gnt_phase, 1);
    chk(!done && !busy, "R8 idle while held", {done, busy}, 0);

    finish_run();
  end
endmodule